// File: doc/BRIEF.md
# Local Interrupt Controller Timer

A down-counting timer for a per-processor interrupt controller. Software programs three things through write strobes: a start count, a divide setting that selects a power-of-two prescale, and the timer's vector-table entry. That entry holds a mask bit, a mode bit that picks one-shot or periodic operation, and an interrupt vector. Writing the start count restarts the prescaler and reloads the down counter. The counter then moves one step for every prescaled tick.

When the counter steps past zero, the block raises a one-cycle expiry pulse and drives the vector from the entry alongside it. In periodic mode the counter reloads at that point. Because of this, expiries stay aligned to the instant of the original load. In one-shot mode the counter stays at zero and nothing further fires. The current count can be read at any time on its own output port.

Top module: `loc_irq_timer`

## Requirements
- R1: After reset the entry is masked, the divide shift is 0, the start count and current count are 0, and no expiry pulse occurs, even after a later start-count write.
- R2: Writing the start count makes the current count read the written value from the next cycle, and restarts the prescale phase.
- R3: The divide field is a shift s from 0 to 7, giving a divide of 2^s. Shift 0 is divide-by-1. The current count drops by one every 2^s cycles after the load edge.
- R4: In one-shot mode (mode bit 0) with start count N > 0, exactly one pulse is visible (N+1)·2^s cycles after the load edge. The current count then holds at 0.
- R5: In periodic mode (mode bit 1) with N > 0, a pulse is visible at every multiple of (N+1)·2^s cycles after the load edge. The current count reads N again in the cycle of each pulse.
- R6: If the mask bit is set at the edge where an expiry falls due, the pulse is suppressed but counting goes on. A periodic timer fires on schedule at its next unmasked expiry. A masked one-shot expiry is used up and does not fire later when unmasked.
- R7: A start count of 0 never produces a pulse, in either mode.
- R8: The expiry pulse is one clock wide. It carries the vector that the entry holds at the edge of expiry.
- R9: A new start-count write during counting drops the old schedule. Expiries are then timed from the new load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntWr | input | 1 | Start-count write strobe |
| cntData | input | CNT_W | Start count value |
| divWr | input | 1 | Divide setting write strobe |
| divShift | input | SHIFT_W | Prescale shift (divide by 2^shift) |
| lvtWr | input | 1 | Vector-table entry write strobe |
| lvtMask | input | 1 | Entry mask bit |
| lvtPeriodic | input | 1 | Entry mode: 1 periodic, 0 one-shot |
| lvtVector | input | VEC_W | Entry vector |
| expPulse | output | 1 | One-cycle expiry pulse |
| expVector | output | VEC_W | Vector of the last expiry |
| curCount | output | CNT_W | Current count |

## Verification
The hardest condition to reach from the ports is a mask that covers exactly one expiry of a running periodic timer, followed by an unmask and a vector change before the next expiry. The bench counts cycles from the load edge and places each entry write at an exact cycle offset. This sets the mask just before one due edge and clears it, with a new vector, just before the following one. A reload placed mid-period, and a masked one-shot expiry followed by an unmask, are placed the same way. For every expected pulse, the scoreboard holds the exact cycle and the vector.

// File: rtl/loc_irq_timer_pkg.sv
package loc_irq_timer_pkg;

  // Strobes and qualifiers passed from control to datapath each cycle
  typedef struct packed {
    logic load;      // start count written this cycle
    logic tick;      // one prescaled tick ends at this edge
    logic periodic;  // entry mode bit
    logic masked;    // entry mask bit
    logic zeroInit;  // stored start count is zero
  } tmrStrobe_t;

endpackage

// File: rtl/loc_irq_timer_ctrl.sv
module loc_irq_timer_ctrl
  import loc_irq_timer_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int SHIFT_W = 3,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cntWr,
  input  logic [CNT_W-1:0]   cntData,
  input  logic               divWr,
  input  logic [SHIFT_W-1:0] divShift,
  input  logic               lvtWr,
  input  logic               lvtMask,
  input  logic               lvtPeriodic,
  input  logic [VEC_W-1:0]   lvtVector,
  output tmrStrobe_t         strobes,
  output logic [CNT_W-1:0]   initCount,
  output logic [VEC_W-1:0]   vector
);

  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [SHIFT_W-1:0] shiftReg;
  logic               maskReg;
  logic               periodicReg;
  logic [PRE_W-1:0]   preCnt;
  logic [PRE_W:0]     divFull;
  logic [PRE_W-1:0]   tickMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg    <= '0;
      maskReg     <= 1'b1;
      periodicReg <= 1'b0;
      vector      <= '0;
      initCount   <= '0;
      preCnt      <= '0;
    end else begin
      if (divWr) shiftReg <= divShift;
      if (lvtWr) begin
        maskReg     <= lvtMask;
        periodicReg <= lvtPeriodic;
        vector      <= lvtVector;
      end
      if (cntWr) begin
        initCount <= cntData;
        preCnt    <= '0;
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  // Tick fires when the low 'shift' bits of the prescaler are all ones
  always_comb begin
    divFull  = (PRE_W+1)'(1) << shiftReg;
    tickMask = PRE_W'(divFull - (PRE_W+1)'(1));
  end

  always_comb begin
    strobes.load     = cntWr;
    strobes.tick     = ((preCnt & tickMask) == tickMask);
    strobes.periodic = periodicReg;
    strobes.masked   = maskReg;
    strobes.zeroInit = (initCount == '0);
  end

  // R3: with no prescale every cycle carries a tick
  a_r3_div_one_every_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (shiftReg == '0) |-> strobes.tick);

  // R2: a count write restarts the prescale phase
  a_r2_phase_restart: assert property (@(posedge clk) disable iff (!rstN)
    $past(cntWr) |-> (preCnt == '0));

endmodule

// File: rtl/loc_irq_timer_dp.sv
module loc_irq_timer_dp
  import loc_irq_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobes,
  input  logic [CNT_W-1:0] loadValue,
  input  logic [CNT_W-1:0] initCount,
  input  logic [VEC_W-1:0] vector,
  output logic             expPulse,
  output logic [VEC_W-1:0] expVector,
  output logic [CNT_W-1:0] curCount
);

  logic spent;   // one-shot expiry already consumed
  logic fireNow;
  logic atZero;

  always_comb begin
    atZero  = (curCount == '0);
    fireNow = !strobes.load && strobes.tick && atZero && !strobes.zeroInit &&
              (strobes.periodic || !spent);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCount  <= '0;
      spent     <= 1'b1;
      expPulse  <= 1'b0;
      expVector <= '0;
    end else begin
      expPulse <= fireNow && !strobes.masked;
      if (fireNow && !strobes.masked) expVector <= vector;
      if (strobes.load) begin
        curCount <= loadValue;
        spent    <= 1'b0;
      end else if (strobes.tick) begin
        if (atZero) begin
          if (strobes.periodic) curCount <= initCount;
          else                  spent    <= 1'b1;
        end else begin
          curCount <= curCount - CNT_W'(1);
        end
      end
    end
  end

  // R8: expiry pulse lasts a single cycle
  a_r8_one_wide: assert property (@(posedge clk) disable iff (!rstN)
    expPulse |=> !expPulse);

  // R7: no expiry from a zero start count
  a_r7_zero_silent: assert property (@(posedge clk) disable iff (!rstN)
    expPulse |-> ($past(initCount) != '0));

  // R4: one-shot expiry leaves the count at zero
  a_r4_oneshot_zero: assert property (@(posedge clk) disable iff (!rstN)
    (expPulse && !$past(strobes.periodic)) |-> (curCount == '0));

  // R5: periodic expiry reloads the count
  a_r5_periodic_reload: assert property (@(posedge clk) disable iff (!rstN)
    (expPulse && $past(strobes.periodic)) |-> (curCount == initCount));

  // R3: count never exceeds the stored start count
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    curCount <= initCount);

endmodule

// File: rtl/loc_irq_timer.sv
module loc_irq_timer
  import loc_irq_timer_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int SHIFT_W = 3,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cntWr,
  input  logic [CNT_W-1:0]   cntData,
  input  logic               divWr,
  input  logic [SHIFT_W-1:0] divShift,
  input  logic               lvtWr,
  input  logic               lvtMask,
  input  logic               lvtPeriodic,
  input  logic [VEC_W-1:0]   lvtVector,
  output logic               expPulse,
  output logic [VEC_W-1:0]   expVector,
  output logic [CNT_W-1:0]   curCount
);

  tmrStrobe_t       strobes;
  logic [CNT_W-1:0] initCount;
  logic [VEC_W-1:0] vector;

  loc_irq_timer_ctrl #(.CNT_W(CNT_W), .SHIFT_W(SHIFT_W), .VEC_W(VEC_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cntWr(cntWr), .cntData(cntData),
    .divWr(divWr), .divShift(divShift),
    .lvtWr(lvtWr), .lvtMask(lvtMask), .lvtPeriodic(lvtPeriodic), .lvtVector(lvtVector),
    .strobes(strobes), .initCount(initCount), .vector(vector)
  );

  loc_irq_timer_dp #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .loadValue(cntData), .initCount(initCount), .vector(vector),
    .expPulse(expPulse), .expVector(expVector), .curCount(curCount)
  );

  // R2: written count is visible on the next cycle
  a_r2_load_value: assert property (@(posedge clk) disable iff (!rstN)
    $past(cntWr) |-> (curCount == $past(cntData)));

  // R9: no expiry in the cycle right after a reload
  a_r9_reload_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $past(cntWr) |-> !expPulse);

endmodule

// File: tb/loc_irq_timer_tb.sv
module loc_irq_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W   = 32;
  localparam int SHIFT_W = 3;
  localparam int VEC_W   = 8;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               cntWr = 1'b0;
  logic [CNT_W-1:0]   cntData = '0;
  logic               divWr = 1'b0;
  logic [SHIFT_W-1:0] divShift = '0;
  logic               lvtWr = 1'b0;
  logic               lvtMask = 1'b0;
  logic               lvtPeriodic = 1'b0;
  logic [VEC_W-1:0]   lvtVector = '0;
  logic               expPulse;
  logic [VEC_W-1:0]   expVector;
  logic [CNT_W-1:0]   curCount;

  loc_irq_timer #(.CNT_W(CNT_W), .SHIFT_W(SHIFT_W), .VEC_W(VEC_W)) u_dut (
    .clk(clk), .rstN(rstN), .cntWr(cntWr), .cntData(cntData),
    .divWr(divWr), .divShift(divShift), .lvtWr(lvtWr), .lvtMask(lvtMask),
    .lvtPeriodic(lvtPeriodic), .lvtVector(lvtVector),
    .expPulse(expPulse), .expVector(expVector), .curCount(curCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int cyc; logic [VEC_W-1:0] vec; } expItem_t;
  expItem_t expQ[$];

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int pulseCnt = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // Scoreboard monitor: compares pulses against the queue of expected expiries
  always @(negedge clk) begin
    if (monOn) begin
      while (expQ.size() > 0 && expQ[0].cyc < cyc) begin
        chk(1'b0, "R4/R5 missed expiry", 0, expQ[0].cyc);
        void'(expQ.pop_front());
      end
      if (expPulse) begin
        pulseCnt++;
        if (expQ.size() == 0 || expQ[0].cyc != cyc) begin
          chk(1'b0, "R6/R7/R9 unexpected expiry", cyc, (expQ.size() > 0) ? expQ[0].cyc : -1);
        end else begin
          chk(expVector == expQ[0].vec, "R8 expiry vector", expVector, expQ[0].vec);
          void'(expQ.pop_front());
        end
      end
    end
  end

  task automatic waitCyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic push(input int c, input logic [VEC_W-1:0] v);
    expItem_t it;
    it.cyc = c; it.vec = v;
    expQ.push_back(it);
  endtask

  // Full setup in one cycle; returns the load cycle index
  task automatic cfg(input int sh, input bit per, input bit msk, input logic [VEC_W-1:0] v,
                     input int n, output int L);
    cntWr = 1'b1; cntData = CNT_W'(n);
    divWr = 1'b1; divShift = SHIFT_W'(sh);
    lvtWr = 1'b1; lvtMask = msk; lvtPeriodic = per; lvtVector = v;
    @(posedge clk);
    @(negedge clk);
    cntWr = 1'b0; divWr = 1'b0; lvtWr = 1'b0;
    L = cyc;
  endtask

  task automatic loadOnly(input int n, output int L);
    cntWr = 1'b1; cntData = CNT_W'(n);
    @(posedge clk);
    @(negedge clk);
    cntWr = 1'b0;
    L = cyc;
  endtask

  task automatic setLvt(input bit msk, input bit per, input logic [VEC_W-1:0] v);
    lvtWr = 1'b1; lvtMask = msk; lvtPeriodic = per; lvtVector = v;
    @(posedge clk);
    @(negedge clk);
    lvtWr = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      chk(1'b0, "watchdog", cyc, 50000);
      summary();
    end
  end

  initial begin
    int L;
    int L2;
    int pc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    monOn = 1'b1;

    // R1: reset state, then a load with the default (masked) entry
    chk(curCount == 0, "R1 reset count", curCount, 0);
    chk(expPulse == 1'b0, "R1 reset pulse", expPulse, 0);
    pc = pulseCnt;
    loadOnly(2, L);
    chk(curCount == 2, "R1/R2 load under default entry", curCount, 2);
    waitCyc(L + 12);
    chk(pulseCnt == pc, "R1 default entry masked", pulseCnt, pc);

    // R2/R4: one-shot, divide 1
    cfg(0, 1'b0, 1'b0, 8'h41, 5, L);
    chk(curCount == 5, "R2 count after write", curCount, 5);
    push(L + 6, 8'h41);
    waitCyc(L + 3);
    chk(curCount == 2, "R3 divide-by-1 step", curCount, 2);
    waitCyc(L + 30);
    chk(curCount == 0, "R4 one-shot holds zero", curCount, 0);

    // R3/R4: one-shot, divide 4
    cfg(2, 1'b0, 1'b0, 8'h42, 3, L);
    push(L + 16, 8'h42);
    waitCyc(L + 3);
    chk(curCount == 3, "R3 no step before 4 cycles", curCount, 3);
    waitCyc(L + 4);
    chk(curCount == 2, "R3 step at 4 cycles", curCount, 2);
    waitCyc(L + 30);
    chk(curCount == 0, "R4 one-shot end", curCount, 0);

    // R3: largest divide, shift 7
    cfg(7, 1'b0, 1'b0, 8'h43, 1, L);
    push(L + 256, 8'h43);
    waitCyc(L + 128);
    chk(curCount == 0, "R3 divide-by-128 step", curCount, 0);
    waitCyc(L + 270);

    // R5/R6/R8: periodic, divide 2, period 6, mask one expiry, change vector
    cfg(1, 1'b1, 1'b0, 8'h55, 2, L);
    push(L + 6, 8'h55); push(L + 12, 8'h55); push(L + 18, 8'h55);
    waitCyc(L + 6);
    chk(curCount == 2, "R5 reload on expiry", curCount, 2);
    waitCyc(L + 19);
    setLvt(1'b1, 1'b1, 8'h55);
    waitCyc(L + 24);
    chk(curCount == 2, "R6 masked period still counts", curCount, 2);
    waitCyc(L + 25);
    push(L + 30, 8'h66);
    setLvt(1'b0, 1'b1, 8'h66);
    waitCyc(L + 31);
    setLvt(1'b1, 1'b1, 8'h66);
    waitCyc(L + 40);

    // R9: reload mid-count re-times the schedule
    cfg(0, 1'b1, 1'b0, 8'h70, 4, L);
    waitCyc(L + 2);
    loadOnly(4, L2);
    push(L2 + 5, 8'h70);
    waitCyc(L2 + 5);
    chk(curCount == 4, "R9 period from new load", curCount, 4);
    setLvt(1'b1, 1'b1, 8'h70);
    waitCyc(L2 + 20);

    // R6: masked one-shot expiry is consumed
    pc = pulseCnt;
    cfg(0, 1'b0, 1'b1, 8'h21, 3, L);
    waitCyc(L + 6);
    setLvt(1'b0, 1'b0, 8'h21);
    waitCyc(L + 30);
    chk(pulseCnt == pc, "R6 masked one-shot never fires", pulseCnt, pc);
    chk(curCount == 0, "R6 one-shot count at zero", curCount, 0);

    // R7: zero start count, both modes
    pc = pulseCnt;
    cfg(0, 1'b0, 1'b0, 8'h11, 0, L);
    waitCyc(L + 20);
    cfg(0, 1'b1, 1'b0, 8'h12, 0, L);
    waitCyc(L + 20);
    chk(pulseCnt == pc, "R7 zero count silent", pulseCnt, pc);
    chk(curCount == 0, "R7 zero count reads zero", curCount, 0);

    chk(expQ.size() == 0, "R4/R5 all expiries seen", expQ.size(), 0);
    done = 1'b1;
    summary();
  end

endmodule